// File: doc/BRIEF.md
# Predicated commit gate

This block sits between issue and register writeback in an in-order pipeline and decides, for every instruction, whether its result is kept. An instruction carries a destination register number, its result value, a load marker and the index of a predicate register. The block owns a small predicate scoreboard. For each predicate register the scoreboard holds a resolved flag and a truth bit, where the truth bit records whether the last value written was nonzero.

A resolved true predicate sends the result to the register file. A resolved false predicate retires the instruction as a no-op with no register write. An unresolved predicate is handled by the policy input. In stall policy the block pushes back on the upstream stage until the predicate resolves. In late policy the instruction is taken at once into a single holding slot, and it commits or is dropped in the cycle after its predicate resolves. Every instruction retires, kept or discarded, so instruction counts stay exact.

Top module: `pred_commit_gate`

## Requirements
- R1: While reset is held and after its release, `out_retire`, `out_wen`, `out_drop` and `in_stall` are low, and every predicate register reads as resolved and true.
- R2: An accepted instruction whose predicate is resolved and nonzero produces, one cycle after acceptance, `out_retire`=1 and `out_wen`=1 with its `out_dst` and `out_val`.
- R3: An accepted instruction whose predicate is resolved and zero produces, one cycle after acceptance, `out_retire`=1, `out_drop`=1 and `out_wen`=0.
- R4: With `late_resolve`=0, a valid instruction whose predicate is unresolved raises `in_stall` in the same cycle and is not accepted. It is accepted in the cycle its predicate becomes resolved.
- R5: With `late_resolve`=1 and the holding slot empty, a valid instruction is never stalled. If its predicate is unresolved, it is parked with its destination, value, load marker and predicate index, and it retires (R2/R3 rules) one cycle after the cycle in which that predicate is resolved.
- R6: While the holding slot is occupied, `in_stall` is high in either policy and no new instruction is accepted.
- R7: Loads obey the same rule: `out_load` is high only together with `out_wen`, and only for an instruction marked as a load.
- R8: Each accepted instruction produces exactly one `out_retire` pulse, in acceptance order. Every `out_retire` has exactly one of `out_wen` and `out_drop` set.
- R9: A predicate set (`pset_en`) makes the register resolved with truth equal to "value nonzero". A clear (`pclr_en`) makes it unresolved from the next cycle. A set and a clear of the same register in one cycle leave it resolved. A set is already visible to an instruction or parked entry read in the same cycle.
- R10: `out_wen` and `out_drop` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| late_resolve | input | 1 | 0: stall on unresolved predicate; 1: park and resolve late |
| in_valid | input | 1 | Instruction present |
| in_dst | input | DST_W | Destination register |
| in_val | input | DATA_W | Result value |
| in_ptag | input | TAG_W | Predicate register index |
| in_load | input | 1 | Instruction is a load |
| in_stall | output | 1 | Backpressure; upstream must hold its fields |
| pset_en | input | 1 | Write a predicate register |
| pset_idx | input | TAG_W | Predicate register written |
| pset_val | input | DATA_W | Value written (only nonzero-ness kept) |
| pclr_en | input | 1 | Mark a predicate register unresolved |
| pclr_idx | input | TAG_W | Predicate register cleared |
| out_retire | output | 1 | One instruction retired this cycle |
| out_wen | output | 1 | Register write enable |
| out_drop | output | 1 | Retired instruction discarded as a no-op |
| out_dst | output | DST_W | Destination of the retired instruction |
| out_val | output | DATA_W | Value of the retired instruction |
| out_load | output | 1 | Retired write comes from a load |

## Verification
The bench builds the gate with four predicate registers, eight destinations and 16-bit values. With so few predicate registers, random sets and clears land on the index an instruction or the parked entry is waiting on almost every few cycles. That makes same-cycle set/clear collisions, bypassed resolutions and back-to-back stalls in both policies common. The policy input is flipped while entries are parked, so draining of the slot under either policy is reached.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  typedef enum logic [1:0] {
    OC_NONE   = 2'd0,
    OC_COMMIT = 2'd1,
    OC_DROP   = 2'd2
  } outcome_e;

  // Outcome of an instruction given the state of its predicate.
  function automatic outcome_e judge(input logic resolved, input logic truth);
    if (!resolved) return OC_NONE;
    return truth ? OC_COMMIT : OC_DROP;
  endfunction

  // Stall decision: slot busy, or stall policy with an unresolved predicate.
  function automatic logic must_stall(input logic slot_busy, input logic valid,
                                      input logic late, input logic resolved);
    return slot_busy | (valid & ~late & ~resolved);
  endfunction
endpackage

// File: rtl/pcg_pred_board.sv
module pcg_pred_board #(
  parameter int NPRED  = 16,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [TAG_W-1:0]  set_idx,
  input  logic [DATA_W-1:0] set_val,
  input  logic              clr_en,
  input  logic [TAG_W-1:0]  clr_idx,
  input  logic [TAG_W-1:0]  rda_idx,
  output logic              rda_rdy,
  output logic              rda_tru,
  input  logic [TAG_W-1:0]  rdb_idx,
  output logic              rdb_rdy,
  output logic              rdb_tru
);
  logic [NPRED-1:0] rdy_q;
  logic [NPRED-1:0] tru_q;
  logic             set_tru;

  assign set_tru = |set_val;

  for (genvar e = 0; e < NPRED; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rdy_q[e] <= 1'b1;
        tru_q[e] <= 1'b1;
      end else if (set_en && set_idx == TAG_W'(e)) begin
        rdy_q[e] <= 1'b1;
        tru_q[e] <= set_tru;
      end else if (clr_en && clr_idx == TAG_W'(e)) begin
        rdy_q[e] <= 1'b0;
      end
    end
  end

  logic hit_a, hit_b;
  assign hit_a   = set_en && (set_idx == rda_idx);
  assign hit_b   = set_en && (set_idx == rdb_idx);
  assign rda_rdy = hit_a | rdy_q[rda_idx];
  assign rda_tru = hit_a ? set_tru : tru_q[rda_idx];
  assign rdb_rdy = hit_b | rdy_q[rdb_idx];
  assign rdb_tru = hit_b ? set_tru : tru_q[rdb_idx];
endmodule

// File: rtl/pcg_hold_slot.sv
module pcg_hold_slot #(
  parameter int DST_W  = 5,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill,
  input  logic              drain,
  input  logic [DST_W-1:0]  fill_dst,
  input  logic [DATA_W-1:0] fill_val,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic              fill_load,
  output logic              busy,
  output logic [DST_W-1:0]  held_dst,
  output logic [DATA_W-1:0] held_val,
  output logic [TAG_W-1:0]  held_tag,
  output logic              held_load
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      held_dst  <= '0;
      held_val  <= '0;
      held_tag  <= '0;
      held_load <= 1'b0;
    end else if (fill) begin
      busy      <= 1'b1;
      held_dst  <= fill_dst;
      held_val  <= fill_val;
      held_tag  <= fill_tag;
      held_load <= fill_load;
    end else if (drain) begin
      busy      <= 1'b0;
    end
  end
endmodule

// File: rtl/pcg_retire_stage.sv
module pcg_retire_stage #(
  parameter int DST_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              keep,
  input  logic [DST_W-1:0]  dst,
  input  logic [DATA_W-1:0] val,
  input  logic              load,
  output logic              retire,
  output logic              wen,
  output logic              drop,
  output logic [DST_W-1:0]  o_dst,
  output logic [DATA_W-1:0] o_val,
  output logic              o_load
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      retire <= 1'b0;
      wen    <= 1'b0;
      drop   <= 1'b0;
      o_load <= 1'b0;
      o_dst  <= '0;
      o_val  <= '0;
    end else begin
      retire <= fire;
      wen    <= fire & keep;
      drop   <= fire & ~keep;
      o_load <= fire & keep & load;
      if (fire) begin
        o_dst <= dst;
        o_val <= val;
      end
    end
  end
endmodule

// File: rtl/pred_commit_gate.sv
module pred_commit_gate #(
  parameter int DATA_W = 32,
  parameter int NREG   = 32,
  parameter int NPRED  = 16,
  parameter int DST_W  = $clog2(NREG),
  parameter int TAG_W  = $clog2(NPRED)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              late_resolve,
  input  logic              in_valid,
  input  logic [DST_W-1:0]  in_dst,
  input  logic [DATA_W-1:0] in_val,
  input  logic [TAG_W-1:0]  in_ptag,
  input  logic              in_load,
  output logic              in_stall,
  input  logic              pset_en,
  input  logic [TAG_W-1:0]  pset_idx,
  input  logic [DATA_W-1:0] pset_val,
  input  logic              pclr_en,
  input  logic [TAG_W-1:0]  pclr_idx,
  output logic              out_retire,
  output logic              out_wen,
  output logic              out_drop,
  output logic [DST_W-1:0]  out_dst,
  output logic [DATA_W-1:0] out_val,
  output logic              out_load
);
  import pcg_pkg::*;

  // Named internal events, also seen by the bound checker.
  logic              in_rdy, in_tru;
  logic              buf_busy, buf_rdy, buf_tru, buf_load;
  logic [DST_W-1:0]  buf_dst;
  logic [DATA_W-1:0] buf_val;
  logic [TAG_W-1:0]  buf_tag;
  logic              buf_fire, acc_fire, direct_fire, park, fire, keep;
  outcome_e          in_oc, buf_oc;
  logic [DST_W-1:0]  sel_dst;
  logic [DATA_W-1:0] sel_val;
  logic              sel_load;

  pcg_pred_board #(.NPRED(NPRED), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_board (
    .clk(clk), .rst_n(rst_n),
    .set_en(pset_en), .set_idx(pset_idx), .set_val(pset_val),
    .clr_en(pclr_en), .clr_idx(pclr_idx),
    .rda_idx(in_ptag), .rda_rdy(in_rdy), .rda_tru(in_tru),
    .rdb_idx(buf_tag), .rdb_rdy(buf_rdy), .rdb_tru(buf_tru)
  );

  assign in_oc       = judge(in_rdy, in_tru);
  assign buf_oc      = judge(buf_rdy, buf_tru);
  assign in_stall    = must_stall(buf_busy, in_valid, late_resolve, in_rdy);
  assign buf_fire    = buf_busy & (buf_oc != OC_NONE);
  assign acc_fire    = in_valid & ~in_stall;
  assign direct_fire = acc_fire & (in_oc != OC_NONE);
  assign park        = acc_fire & (in_oc == OC_NONE);
  assign fire        = buf_fire | direct_fire;

  always_comb begin
    if (buf_busy) begin
      keep     = (buf_oc == OC_COMMIT);
      sel_dst  = buf_dst;
      sel_val  = buf_val;
      sel_load = buf_load;
    end else begin
      keep     = (in_oc == OC_COMMIT);
      sel_dst  = in_dst;
      sel_val  = in_val;
      sel_load = in_load;
    end
  end

  pcg_hold_slot #(.DST_W(DST_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .fill(park), .drain(buf_fire),
    .fill_dst(in_dst), .fill_val(in_val), .fill_tag(in_ptag), .fill_load(in_load),
    .busy(buf_busy), .held_dst(buf_dst), .held_val(buf_val),
    .held_tag(buf_tag), .held_load(buf_load)
  );

  pcg_retire_stage #(.DST_W(DST_W), .DATA_W(DATA_W)) u_ret (
    .clk(clk), .rst_n(rst_n),
    .fire(fire), .keep(keep), .dst(sel_dst), .val(sel_val), .load(sel_load),
    .retire(out_retire), .wen(out_wen), .drop(out_drop),
    .o_dst(out_dst), .o_val(out_val), .o_load(out_load)
  );
endmodule

// File: rtl/pcg_gate_checker.sv
module pcg_gate_checker (
  input logic clk,
  input logic rst_n,
  input logic late_resolve,
  input logic in_valid,
  input logic in_stall,
  input logic buf_busy,
  input logic park,
  input logic out_retire,
  input logic out_wen,
  input logic out_drop,
  input logic out_load
);
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_wen && out_drop));

  p_retire_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_retire |-> (out_wen || out_drop));

  p_kind_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wen || out_drop) |-> out_retire);

  p_load_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_load |-> out_wen);

  p_slot_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_busy |-> in_stall);

  p_late_flows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (late_resolve && in_valid && !buf_busy) |-> !in_stall);

  p_park_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
    park |=> buf_busy);

  p_park_policy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    park |-> late_resolve);

  p_stall_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!late_resolve && in_valid && in_stall && !buf_busy) |=> !out_retire);
endmodule

bind pred_commit_gate pcg_gate_checker u_gate_chk (
  .clk(clk), .rst_n(rst_n), .late_resolve(late_resolve),
  .in_valid(in_valid), .in_stall(in_stall), .buf_busy(buf_busy), .park(park),
  .out_retire(out_retire), .out_wen(out_wen), .out_drop(out_drop),
  .out_load(out_load)
);

// File: tb/pred_commit_gate_bench.sv
module pred_commit_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NR = 8;
  localparam int NP = 4;
  localparam int DSTW = 3;
  localparam int TAGW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic late_resolve = 1'b0;
  logic in_valid = 1'b0;
  logic [DSTW-1:0] in_dst = '0;
  logic [DW-1:0] in_val = '0;
  logic [TAGW-1:0] in_ptag = '0;
  logic in_load = 1'b0;
  logic in_stall;
  logic pset_en = 1'b0;
  logic [TAGW-1:0] pset_idx = '0;
  logic [DW-1:0] pset_val = '0;
  logic pclr_en = 1'b0;
  logic [TAGW-1:0] pclr_idx = '0;
  logic out_retire, out_wen, out_drop, out_load;
  logic [DSTW-1:0] out_dst;
  logic [DW-1:0] out_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_commit_gate #(.DATA_W(DW), .NREG(NR), .NPRED(NP)) u_pred_commit_gate (
    .clk(clk), .rst_n(rst_n), .late_resolve(late_resolve),
    .in_valid(in_valid), .in_dst(in_dst), .in_val(in_val), .in_ptag(in_ptag),
    .in_load(in_load), .in_stall(in_stall),
    .pset_en(pset_en), .pset_idx(pset_idx), .pset_val(pset_val),
    .pclr_en(pclr_en), .pclr_idx(pclr_idx),
    .out_retire(out_retire), .out_wen(out_wen), .out_drop(out_drop),
    .out_dst(out_dst), .out_val(out_val), .out_load(out_load)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  bit cmp_on = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference model.
  bit m_rdy[NP];
  bit m_tru[NP];
  bit m_bv, m_bload;
  int m_bdst, m_bval, m_btag;
  bit e_ret, e_wen, e_drop, e_load;
  int e_dst, e_val;
  int q_acc[$];

  function automatic bit rdy_of(int idx);
    return m_rdy[idx] || (pset_en && int'(pset_idx) == idx);
  endfunction
  function automatic bit tru_of(int idx);
    if (pset_en && int'(pset_idx) == idx) return (pset_val != 0);
    return m_tru[idx];
  endfunction
  function automatic bit exp_stall();
    if (m_bv) return 1;
    return in_valid && !late_resolve && !rdy_of(int'(in_ptag));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin m_rdy[i] = 1; m_tru[i] = 1; end
      m_bv = 0; e_ret = 0; e_wen = 0; e_drop = 0; e_load = 0;
    end else begin
      e_ret = 0; e_wen = 0; e_drop = 0; e_load = 0;
      if (m_bv) begin
        if (rdy_of(m_btag)) begin
          e_ret = 1; e_wen = tru_of(m_btag); e_drop = !e_wen;
          e_load = e_wen && m_bload; e_dst = m_bdst; e_val = m_bval;
          m_bv = 0;
        end
      end else if (in_valid && !exp_stall()) begin
        if (rdy_of(int'(in_ptag))) begin
          e_ret = 1; e_wen = tru_of(int'(in_ptag)); e_drop = !e_wen;
          e_load = e_wen && in_load; e_dst = int'(in_dst); e_val = int'(in_val);
        end else begin
          m_bv = 1; m_bdst = int'(in_dst); m_bval = int'(in_val);
          m_btag = int'(in_ptag); m_bload = in_load;
        end
      end
      if (pclr_en) m_rdy[int'(pclr_idx)] = 0;
      if (pset_en) begin
        m_rdy[int'(pset_idx)] = 1;
        m_tru[int'(pset_idx)] = (pset_val != 0);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(late_resolve ? "R6/R5 in_stall" : "R4/R6 in_stall", in_stall, exp_stall());
      chk("R8 out_retire", out_retire, e_ret);
      chk("R2 out_wen", out_wen, e_wen);
      chk("R3 out_drop", out_drop, e_drop);
      chk("R7 out_load", out_load, e_load);
      chk("R10 exclusive", out_wen & out_drop, 1'b0);
      if (e_ret) begin
        chk("R5 out_dst", out_dst, e_dst[DSTW-1:0]);
        chk("R5 out_val", out_val, e_val[DW-1:0]);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected<=200000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    in_valid = 0; pset_en = 0; pclr_en = 0;
  endtask

  task automatic instr(input int dst, input int val, input int tag, input bit ld);
    in_valid = 1; in_dst = dst[DSTW-1:0]; in_val = val[DW-1:0];
    in_ptag = tag[TAGW-1:0]; in_load = ld;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 retire in reset", out_retire, 1'b0);
    chk("R1 wen in reset", out_wen, 1'b0);
    rst_n = 1;
    #1;
    chk("R1 stall after reset", in_stall, 1'b0);
    chk("R1 drop after reset", out_drop, 1'b0);
    cmp_on = 1;
    step();

    // R1/R2: unwritten predicate reads true, commit.
    instr(5, 16'h1234, 1, 0); step();
    // R3: set predicate 2 to zero, then use it.
    idle(); pset_en = 1; pset_idx = 2; pset_val = 0; step();
    pset_en = 0; instr(6, 16'hbeef, 2, 1); step();
    // R4: clear predicate 1, stall, then resolve nonzero.
    idle(); pclr_en = 1; pclr_idx = 1; step();
    pclr_en = 0; instr(3, 16'h0042, 1, 1); step(); step(); step();
    pset_en = 1; pset_idx = 1; pset_val = 16'h0007; step();
    idle(); step();
    // R5/R6: late policy, park a load on unresolved predicate 3, then drop.
    late_resolve = 1; pclr_en = 1; pclr_idx = 3; step();
    pclr_en = 0; instr(7, 16'h5555, 3, 1); step();
    instr(2, 16'h0101, 0, 0); step(); step();
    pset_en = 1; pset_idx = 3; pset_val = 0; step();
    pset_en = 0; step(); idle(); step();
    // R9: set and clear of the same register in one cycle; set wins.
    late_resolve = 0;
    pclr_en = 1; pclr_idx = 0; pset_en = 1; pset_idx = 0; pset_val = 16'h0001; step();
    idle(); instr(4, 16'h0abc, 0, 0); step();
    idle(); #3;
    chk("R9 set wins over clear", out_wen, 1'b1);
    chk("R9 committed dst", out_dst, 3'd4);
    step();

    // Random phase: both policies, heavy predicate churn.
    for (int n = 0; n < 4000; n++) begin
      if ((n % 250) == 0) late_resolve = $urandom_range(0, 1);
      if (!(in_valid && in_stall)) begin
        in_valid = ($urandom_range(0, 9) < 7);
        in_dst = DSTW'($urandom); in_val = DW'($urandom);
        in_ptag = TAGW'($urandom); in_load = $urandom_range(0, 1);
      end
      pset_en = ($urandom_range(0, 9) < 3);
      pset_idx = TAGW'($urandom);
      pset_val = ($urandom_range(0, 1) == 0) ? '0 : DW'($urandom_range(1, 65535));
      pclr_en = ($urandom_range(0, 9) < 3);
      pclr_idx = TAGW'($urandom);
      q_acc.push_back(n);
      step();
    end
    idle(); pset_en = 1; pset_idx = 0; pset_val = 1;
    for (int k = 0; k < NP; k++) begin pset_idx = k[TAGW-1:0]; step(); end
    idle(); step(); step();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule